// File: doc/BRIEF.md
# One-Time-Programmable Protection Register File

This block models the small protection register set found beside a flash array. It keeps two regions of four 16-bit words each. The first region holds an identifier fixed at manufacture, and the second is free for the system to write once. A lock word at the bottom of the window decides whether each region may still be programmed. Every storage bit behaves like an unerased flash cell. A program can pull a bit from 1 to 0, and nothing in the block can raise it again.

The host uses one write strobe with an 8-bit address and a 16-bit data bus. A register program takes two writes. The first write carries the register-setup command in the low byte. The second write carries the target address and the data. The second write always returns the block to read mode. Reads are combinational from the address bus. Programs to a locked region, to a word outside the window, or into the window after an array-setup command are refused. A refused program sets a sticky error flag, and a clear-status command resets that flag.

Top module: `otp_prot_regs`

## Requirements
- R1: After reset the word at 80h reads FFFEh (bit 0 = 0, so the identifier region is locked). The words at 81h+k (k = 0..3) read FACTORY_ID[16k+15:16k]. The words 85h–88h read FFFFh, and prot_err is 0.
- R2: A write whose low data byte is C0h, made in read mode, followed by a write to 85h–88h while bit 1 of the lock word is 1, stores old & data in that word.
- R3: Programming never turns a stored 0 into a 1. Data bits that are 1 leave the stored bit as it was.
- R4: A register program to 81h–84h, whose lock bit 0 is 0, leaves the word unchanged and sets prot_err.
- R5: A register program of FFFDh to 80h clears lock bit 1. Any later register program to 85h–88h leaves the word unchanged and sets prot_err.
- R6: A register program to 80h stores lock & data. Writing FFFFh leaves the lock word as it was and does not set prot_err.
- R7: A register program to an address outside 80h–88h changes no word and sets prot_err.
- R8: After an array-setup command (low byte 40h), the next write to 80h–88h changes nothing and sets prot_err. The next write to any other address leaves prot_err as it was.
- R9: A write in read mode with low byte 50h clears prot_err. Otherwise prot_err, once set, stays set through later commands and successful programs.
- R10: Only the low byte of a read-mode write is decoded as a command, and unknown command bytes are ignored. After the second write of either sequence the block is back in read mode, so a further data write does not program.
- R11: Reads of any address outside 80h–88h return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Word address for reads and writes |
| bus_wdata | input | 16 | Write data; low byte is the command in read mode |
| bus_rdata | output | 16 | Word at bus_addr (0000h outside the window) |
| prot_err | output | 1 | Sticky flag for a refused program |

## Verification
The bench targets the sequences where a wrong design would leak state. A user-region program after the lock word has been cleared must not reach storage, or a locked identity could be rewritten. A program carrying 1s over 0s must not restore bits, which a design that stores the data directly would do. A write to the lock word must not relock or unlock a region. A data write that follows a finished program must not program a second time, which a design that stays in setup mode would do. It also checks that the error flag stays set across a later successful program, that only the clear command resets it, and that an array-setup sequence aimed into the window is refused while one aimed elsewhere is not.

// File: rtl/otp_prot_pkg.sv
package otp_prot_pkg;

    typedef enum logic [1:0] {
        MODE_READ      = 2'd0,
        MODE_REG_SETUP = 2'd1,
        MODE_ARR_SETUP = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CLS_LOCK    = 2'd0,
        CLS_REGION  = 2'd1,
        CLS_OUTSIDE = 2'd2
    } addr_cls_e;

    localparam logic [7:0] CMD_REG_SETUP = 8'hC0;
    localparam logic [7:0] CMD_ARR_SETUP = 8'h40;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
    import otp_prot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_REGIONS = 2,
    parameter int REGION_WORDS = 4,
    parameter logic [ADDR_W-1:0] BASE = 8'h80,
    localparam int TOTAL_WORDS = NUM_REGIONS * REGION_WORDS,
    localparam int FLAT_W = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1,
    localparam int RGN_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_e         cls,
    output logic [FLAT_W-1:0] flat_idx,
    output logic [RGN_W-1:0]  region
);
    int off;

    always_comb begin
        off      = int'(addr) - int'(BASE);
        cls      = CLS_OUTSIDE;
        flat_idx = '0;
        region   = '0;
        if (off == 0) begin
            cls = CLS_LOCK;
        end else if (off >= 1 && off <= TOTAL_WORDS) begin
            cls      = CLS_REGION;
            flat_idx = FLAT_W'(off - 1);
            region   = RGN_W'((off - 1) / REGION_WORDS);
        end
    end
endmodule

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
    import otp_prot_pkg::*;
(
    input  mode_e      mode_q,
    input  logic       wr_en,
    input  logic [7:0] cmd,
    output mode_e      mode_d,
    output logic       pgm_req,
    output logic       arr_req,
    output logic       clr_req
);
    always_comb begin
        mode_d  = mode_q;
        pgm_req = 1'b0;
        arr_req = 1'b0;
        clr_req = 1'b0;
        case (mode_q)
            MODE_READ: begin
                if (wr_en) begin
                    case (cmd)
                        CMD_REG_SETUP: mode_d = MODE_REG_SETUP;
                        CMD_ARR_SETUP: mode_d = MODE_ARR_SETUP;
                        CMD_CLR_STAT:  clr_req = 1'b1;
                        default:       mode_d = MODE_READ;
                    endcase
                end
            end
            MODE_REG_SETUP: begin
                if (wr_en) begin
                    pgm_req = 1'b1;
                    mode_d  = MODE_READ;
                end
            end
            MODE_ARR_SETUP: begin
                if (wr_en) begin
                    arr_req = 1'b1;
                    mode_d  = MODE_READ;
                end
            end
            default: mode_d = MODE_READ;
        endcase
    end
endmodule

// File: rtl/otp_grant.sv
module otp_grant
    import otp_prot_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    localparam int RGN_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   pgm_req,
    input  logic                   arr_req,
    input  addr_cls_e              cls,
    input  logic [RGN_W-1:0]       region,
    input  logic [NUM_REGIONS-1:0] open_bits,
    output logic                   lock_wr,
    output logic                   word_wr,
    output logic                   viol
);
    always_comb begin
        lock_wr = 1'b0;
        word_wr = 1'b0;
        viol    = 1'b0;
        if (pgm_req) begin
            case (cls)
                CLS_LOCK:   lock_wr = 1'b1;
                CLS_REGION: begin
                    if (open_bits[region]) word_wr = 1'b1;
                    else                   viol    = 1'b1;
                end
                default:    viol = 1'b1;
            endcase
        end else if (arr_req) begin
            viol = (cls != CLS_OUTSIDE);
        end
    end
endmodule

// File: rtl/otp_read_mux.sv
module otp_read_mux
    import otp_prot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TOTAL_WORDS = 8,
    localparam int FLAT_W = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1
) (
    input  addr_cls_e                             cls,
    input  logic [FLAT_W-1:0]                     flat_idx,
    input  logic [TOTAL_WORDS-1:0][DATA_W-1:0]    words,
    input  logic [DATA_W-1:0]                     lock_word,
    output logic [DATA_W-1:0]                     rdata
);
    always_comb begin
        case (cls)
            CLS_LOCK:   rdata = lock_word;
            CLS_REGION: rdata = words[flat_idx];
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/otp_prot_regs.sv
module otp_prot_regs
    import otp_prot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NUM_REGIONS = 2,
    parameter int REGION_WORDS = 4,
    parameter logic [ADDR_W-1:0] BASE = 8'h80,
    parameter logic [REGION_WORDS*DATA_W-1:0] FACTORY_ID = 64'h1A2B_3C4D_5E6F_7081
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_err
);
    localparam int TOTAL_WORDS = NUM_REGIONS * REGION_WORDS;
    localparam int FLAT_W = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1;
    localparam int RGN_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    typedef logic [TOTAL_WORDS-1:0][DATA_W-1:0] words_t;

    typedef struct packed {
        mode_e             mode;
        logic              err;
        logic [DATA_W-1:0] lock;
        words_t            words;
    } state_t;

    function automatic words_t init_words();
        words_t w;
        for (int i = 0; i < TOTAL_WORDS; i++) begin
            if (i < REGION_WORDS) w[i] = FACTORY_ID[i*DATA_W +: DATA_W];
            else                  w[i] = '1;
        end
        return w;
    endfunction

    localparam words_t WORDS_RST = init_words();
    localparam logic [DATA_W-1:0] LOCK_RST = {{(DATA_W-1){1'b1}}, 1'b0};

    state_t st_q, st_d;

    addr_cls_e         cls;
    logic [FLAT_W-1:0] flat_idx;
    logic [RGN_W-1:0]  region;
    mode_e             mode_nx;
    logic              pgm_req, arr_req, clr_req;
    logic              lock_wr, word_wr, viol;

    otp_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
        .REGION_WORDS(REGION_WORDS), .BASE(BASE)
    ) u_decode (
        .addr(bus_addr), .cls(cls), .flat_idx(flat_idx), .region(region)
    );

    otp_cmd_decode u_cmd (
        .mode_q(st_q.mode), .wr_en(bus_wr), .cmd(bus_wdata[7:0]),
        .mode_d(mode_nx), .pgm_req(pgm_req), .arr_req(arr_req), .clr_req(clr_req)
    );

    otp_grant #(.NUM_REGIONS(NUM_REGIONS)) u_grant (
        .pgm_req(pgm_req), .arr_req(arr_req), .cls(cls), .region(region),
        .open_bits(st_q.lock[NUM_REGIONS-1:0]),
        .lock_wr(lock_wr), .word_wr(word_wr), .viol(viol)
    );

    otp_read_mux #(.DATA_W(DATA_W), .TOTAL_WORDS(TOTAL_WORDS)) u_rmux (
        .cls(cls), .flat_idx(flat_idx), .words(st_q.words),
        .lock_word(st_q.lock), .rdata(bus_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_nx;
        if (clr_req) st_d.err = 1'b0;
        if (viol)    st_d.err = 1'b1;
        if (lock_wr) st_d.lock = st_q.lock & bus_wdata;
        if (word_wr) st_d.words[flat_idx] = st_q.words[flat_idx] & bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_READ;
            st_q.err   <= 1'b0;
            st_q.lock  <= LOCK_RST;
            st_q.words <= WORDS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_err = st_q.err;
endmodule

// File: rtl/otp_prot_regs_chk.sv
module otp_prot_regs_chk
    import otp_prot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NUM_REGIONS = 2,
    parameter int REGION_WORDS = 4,
    parameter logic [ADDR_W-1:0] BASE = 8'h80,
    localparam int TOTAL_WORDS = NUM_REGIONS * REGION_WORDS
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [7:0]                      cmd,
    input mode_e                           mode_q,
    input logic                            err_q,
    input logic [DATA_W-1:0]               lock_q,
    input logic [TOTAL_WORDS*DATA_W-1:0]   words_q
);
    logic in_window, in_user;
    assign in_window = (int'(bus_addr) >= int'(BASE)) &&
                       (int'(bus_addr) <= int'(BASE) + TOTAL_WORDS);
    assign in_user   = (int'(bus_addr) >= int'(BASE) + 1 + REGION_WORDS) &&
                       (int'(bus_addr) <= int'(BASE) + 2 * REGION_WORDS);

    assert_words_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (words_q & ~$past(words_q)) == '0);

    assert_factory_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(words_q[REGION_WORDS*DATA_W-1:0]));

    assert_locked_user_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode_q == MODE_REG_SETUP && !lock_q[1] && in_user)
        |=> ($stable(words_q) && err_q));

    assert_lock_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~$past(lock_q)) == '0);

    assert_outside_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode_q == MODE_REG_SETUP && !in_window)
        |=> (err_q && $stable(words_q) && $stable(lock_q)));

    assert_arr_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode_q == MODE_ARR_SETUP && in_window)
        |=> (err_q && $stable(words_q) && $stable(lock_q)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode_q == MODE_READ && cmd == CMD_CLR_STAT) |=> !err_q);

    assert_back_to_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode_q != MODE_READ) |=> (mode_q == MODE_READ));
endmodule

bind otp_prot_regs otp_prot_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS),
    .REGION_WORDS(REGION_WORDS), .BASE(BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cmd(bus_wdata[7:0]), .mode_q(st_q.mode), .err_q(st_q.err),
    .lock_q(st_q.lock), .words_q(st_q.words)
);

// File: tb/otp_prot_regs_tb.sv
`timescale 1ns/1ps
module otp_prot_regs_tb;
    localparam logic [63:0] FID = 64'h1A2B_3C4D_5E6F_7081;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        prot_err;

    always #10 clk = ~clk;

    otp_prot_regs #(.FACTORY_ID(FID)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_err(prot_err)
    );

    // behavioural reference
    logic [15:0] m_words [8];
    logic [15:0] m_lock;
    logic        m_err;
    int          m_mode;   // 0 read, 1 register setup, 2 array setup
    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_req = "R1";
    bit          done = 0;

    function automatic logic [15:0] m_read(input logic [7:0] a);
        if (a == 8'h80) return m_lock;
        if (a >= 8'h81 && a <= 8'h88) return m_words[a - 8'h81];
        return 16'h0000;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [15:0] d);
        int idx;
        if (m_mode == 0) begin
            if (d[7:0] == 8'hC0) m_mode = 1;
            else if (d[7:0] == 8'h40) m_mode = 2;
            else if (d[7:0] == 8'h50) m_err = 1'b0;
        end else if (m_mode == 1) begin
            m_mode = 0;
            if (a == 8'h80) m_lock = m_lock & d;
            else if (a >= 8'h81 && a <= 8'h88) begin
                idx = a - 8'h81;
                if (m_lock[idx / 4]) m_words[idx] = m_words[idx] & d;
                else m_err = 1'b1;
            end else m_err = 1'b1;
        end else begin
            m_mode = 0;
            if (a >= 8'h80 && a <= 8'h88) m_err = 1'b1;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (bus_rdata !== m_read(bus_addr)) begin
                n_bad++;
                $display("FAIL %s rdata @%h: got %h expected %h", cur_req, bus_addr, bus_rdata, m_read(bus_addr));
            end
            n_cmp++;
            if (prot_err !== m_err) begin
                n_bad++;
                $display("FAIL %s prot_err: got %b expected %b", cur_req, prot_err, m_err);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        model_write(a, d);
        #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        @(posedge clk);
        #2;
    endtask

    task automatic prog(input logic [7:0] a, input logic [15:0] d);
        wr(8'h00, 16'h00C0);
        wr(a, d);
        rd(a);
    endtask

    task automatic scan();
        for (int a = 8'h7E; a <= 8'h8A; a++) rd(8'(a));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_words[i] = (i < 4) ? FID[i*16 +: 16] : 16'hFFFF;
        m_lock = 16'hFFFE; m_err = 1'b0; m_mode = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        cur_req = "R1"; scan();
        cur_req = "R2"; prog(8'h85, 16'hF0F0); prog(8'h86, 16'h1234);
        cur_req = "R3"; prog(8'h85, 16'hFFFF); prog(8'h85, 16'h0F0F); prog(8'h86, 16'hFFFF);
        cur_req = "R4"; prog(8'h82, 16'h0000); prog(8'h81, 16'h0000);
        cur_req = "R9"; prog(8'h87, 16'h00FF); wr(8'h00, 16'h0050); rd(8'h87);
        wr(8'h00, 16'h0050); rd(8'h80);
        cur_req = "R7"; prog(8'h90, 16'h0000); wr(8'h00, 16'h0050);
        prog(8'h7F, 16'h0000); wr(8'h00, 16'h0050); rd(8'h85);
        cur_req = "R8"; wr(8'h00, 16'h0040); wr(8'h86, 16'h0000); rd(8'h86);
        wr(8'h00, 16'h0050); wr(8'h00, 16'h0040); wr(8'h20, 16'h0000); rd(8'h86);
        wr(8'h00, 16'h0040); wr(8'h80, 16'h0000); scan(); wr(8'h00, 16'h0050);
        cur_req = "R10"; wr(8'h88, 16'h0000); rd(8'h88); wr(8'h88, 16'h1234); rd(8'h88);
        wr(8'h00, 16'hABC0); wr(8'h88, 16'h00FF); rd(8'h88);
        wr(8'h88, 16'h0000); rd(8'h88);
        cur_req = "R11"; rd(8'h00); rd(8'h89); rd(8'hFF); rd(8'h7F);
        cur_req = "R6"; prog(8'h80, 16'hFFFF); prog(8'h80, 16'h7FFF);
        cur_req = "R5"; prog(8'h80, 16'hFFFD); prog(8'h88, 16'h0000); prog(8'h87, 16'h0000);
        scan();
        cur_req = "R6"; wr(8'h00, 16'h0050); prog(8'h80, 16'hFFFF); scan();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule